// File: doc/BRIEF.md
# Four-Channel Half-Step Tick Generator

The block derives four independent clock-enable strobes from one peripheral clock. A single 32-bit configuration word carries four 8-bit divisor fields, one per channel. A channel with field value N emits, on average, one tick every (N+2)/2 input cycles. An odd N therefore gives a half-integer average ratio: N=1 gives 1.5 and N=3 gives 2.5. The block produces strobes only. Downstream logic qualifies its own flops with a tick and never uses a tick as a clock.

Each channel keeps a small phase accumulator. The accumulator gains 2 on every cycle. When it reaches the span N+2, the span is subtracted and the tick fires for that cycle. The block holds a registered copy of every field. When a field differs from its copy, that channel restarts from phase zero, so the next tick follows the new ratio without a stale partial period. The other channels carry on undisturbed. Typical use: channel 1 paces fast-plus bus timing, channel 2 fast mode, channel 3 standard mode and channel 4 a slow timeout counter.

Top module: `hsdiv_top`

## Requirements
- R1: Configuration bits [7:0] control tick_o[0], bits [15:8] control tick_o[1], bits [23:16] control tick_o[2] and bits [31:24] control tick_o[3].
- R2: Count the input edges after a channel's restart edge as 1, 2, 3 and so on. Through edge k, the channel has emitted exactly floor(2k/(N+2)) ticks. A tick is therefore present after edge k exactly when floor(2k/(N+2)) is larger than floor(2(k-1)/(N+2)).
- R3: With N=0, a channel ticks on every cycle, except on its restart edge.
- R4: With N of 2 or more, a channel never ticks on two adjacent cycles.
- R5: On the first edge that samples a field different from the channel's held copy, the channel emits no tick, clears its phase and adopts the new field. Edge numbering for R2 restarts there.
- R6: A change in one field leaves the tick sequence of every other channel unchanged.
- R7: While reset is high, all ticks are low. Reset clears every phase and sets the held field copies to 0x62220803. If the configuration equals that value when reset is released, no restart occurs, and the first edge after release counts as k=1.
- R8: With the default configuration held for the 1000 edges after reset, the channels emit 400, 200, 55 and 20 ticks, in channel order. This matches 20 MHz, 10 MHz and about 2.78 MHz from a 50 MHz input on channels 1 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Four packed 8-bit divisor fields |
| tick_o | output | 4 | One-cycle enable strobe per channel |

## Verification
Each tick is registered once, so the value visible after edge k is the decision taken at edge k. A field change driven between edges is seen by the following edge, and that edge is edge 0 of the new sequence. The bench drives configuration at the falling edge. On every rising edge it updates a closed-form model of floor(2k/(N+2)) for each channel and compares all four ticks at the next falling edge. Rate totals, adjacency and the reset case are also counted over fixed windows measured in edges from the reset release.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

    localparam int unsigned FIELD_W = 8;
    localparam int unsigned NUM_CH  = 4;
    localparam int unsigned CFG_W   = FIELD_W * NUM_CH;
    localparam int unsigned ACC_W   = FIELD_W + 1;
    localparam int unsigned STEP    = 2;

    localparam logic [CFG_W-1:0] CFG_DEFAULT = 32'h6222_0803;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [ACC_W-1:0]   acc_t;

    typedef struct packed {
        acc_t acc;
        logic tick;
    } ch_state_t;

    function automatic field_t get_field(logic [CFG_W-1:0] cfg, int unsigned idx);
        return cfg[idx*FIELD_W +: FIELD_W];
    endfunction

    function automatic acc_t span_of(field_t f);
        return acc_t'(f) + acc_t'(STEP);
    endfunction

endpackage

// File: rtl/hsdiv_cfg_watch.sv
module hsdiv_cfg_watch
    import hsdiv_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = CFG_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_i,
    output field_t            held_o [NUM_CH],
    output logic [NUM_CH-1:0] restart_o
);

    field_t held_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[g] <= get_field(RESET_CFG, g);
            end else begin
                held_q[g] <= get_field(cfg_i, g);
            end
        end

        assign restart_o[g] = (get_field(cfg_i, g) != held_q[g]);
        assign held_o[g]    = held_q[g];

        // R5: a restart edge always leaves the held copy equal to the sampled field
        a_r5_adopt_field: assert property (@(posedge clk) disable iff (rst)
            restart_o[g] |=> (held_q[g] == $past(get_field(cfg_i, g))));
    end

endmodule

// File: rtl/hsdiv_channel.sv
module hsdiv_channel
    import hsdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  field_t held_i,
    input  logic   restart_i,
    output logic   tick_o
);

    ch_state_t st_q, st_d;
    acc_t      span;
    acc_t      sum;

    always_comb begin
        span = span_of(held_i);
        sum  = st_q.acc + acc_t'(STEP);
        st_d = st_q;
        if (restart_i) begin
            st_d = '0;
        end else if (sum >= span) begin
            st_d.acc  = sum - span;
            st_d.tick = 1'b1;
        end else begin
            st_d.acc  = sum;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R2: phase always stays below the span of the held field
    a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < span_of(held_i));

    // R5: the edge that restarts a channel leaves it silent with zero phase
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (st_q.acc == '0 && !tick_o));

    // R4: with a field of 2 or more, a tick is never followed by another
    a_r4_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        (tick_o && held_i >= field_t'(2)) |=> !tick_o);

    // R3: a zero field with no restart ticks on the next edge
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (held_i == '0 && !restart_i) |=> tick_o);

endmodule

// File: rtl/hsdiv_top.sv
module hsdiv_top
    import hsdiv_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = CFG_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [NUM_CH-1:0] tick_o
);

    field_t            held [NUM_CH];
    logic [NUM_CH-1:0] restart;

    hsdiv_cfg_watch #(
        .RESET_CFG (RESET_CFG)
    ) u_watch (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg_i),
        .held_o    (held),
        .restart_o (restart)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        hsdiv_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .held_i    (held[g]),
            .restart_i (restart[g]),
            .tick_o    (tick_o[g])
        );
    end

    // R7: every strobe is low on the first edge after reset was sampled
    a_r7_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (tick_o == '0));

endmodule

// File: tb/hsdiv_top_tb.sv
module hsdiv_top_tb;

    localparam logic [31:0] DEF_CFG = 32'h6222_0803;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg = DEF_CFG;
    logic [3:0]  tick;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R7";

    int  mk   [4];
    int  mref [4];
    logic [3:0] exp_tick = '0;
    logic [3:0] prev_tick = '0;
    int  adj_viol = 0;
    int  tick_cnt [4];

    hsdiv_top u_dut (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .tick_o (tick)
    );

    always #2.5 clk = ~clk;

    function automatic int fld(logic [31:0] c, int i);
        return int'(c[i*8 +: 8]);
    endfunction

    function automatic logic model_tick(int k, int f);
        int d;
        d = f + 2;
        return ((2*k)/d) != ((2*(k-1))/d);
    endfunction

    // closed-form reference model, updated on each rising edge
    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < 4; i++) begin
            if (rst) begin
                mk[i] = 0;
                mref[i] = fld(DEF_CFG, i);
                exp_tick[i] = 1'b0;
            end else if (fld(cfg, i) != mref[i]) begin
                mk[i] = 0;
                mref[i] = fld(cfg, i);
                exp_tick[i] = 1'b0;
            end else begin
                mk[i] = mk[i] + 1;
                exp_tick[i] = model_tick(mk[i], mref[i]);
            end
        end
    end

    task automatic compare_cycle();
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (tick[i] !== exp_tick[i]) begin
                errors++;
                $display("FAIL %s ch%0d cycle %0d: actual=%b expected=%b",
                         tag, i, cycles, tick[i], exp_tick[i]);
            end
            if (tick[i] && prev_tick[i] && mref[i] >= 2 && mk[i] > 1) adj_viol++;
            if (tick[i]) tick_cnt[i]++;
        end
        prev_tick = tick;
    endtask

    task automatic run(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare_cycle();
        end
    endtask

    task automatic set_cfg(logic [31:0] v);
        @(negedge clk);
        compare_cycle();
        cfg = v;
    endtask

    initial begin
        #(WATCHDOG * 5.0);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [31:0] v;
        seed = 32'd12345;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) tick_cnt[i] = 0;

        // R7: reset state
        repeat (4) @(negedge clk);
        checks++;
        if (tick !== 4'b0000) begin
            errors++;
            $display("FAIL R7 reset: actual=%b expected=0000", tick);
        end
        rst = 1'b0;

        // R8 and R7: default config rates over 1000 edges after release
        tag = "R8";
        run(1000);
        begin
            int exp_cnt [4];
            exp_cnt[0] = 400; exp_cnt[1] = 200; exp_cnt[2] = 55; exp_cnt[3] = 20;
            for (int i = 0; i < 4; i++) begin
                checks++;
                if (tick_cnt[i] != exp_cnt[i]) begin
                    errors++;
                    $display("FAIL R8 ch%0d count: actual=%0d expected=%0d",
                             i, tick_cnt[i], exp_cnt[i]);
                end
            end
        end

        // R1: distinct fields on every byte lane
        tag = "R1";
        set_cfg(32'h05_00_FF_01);
        run(600);

        // R3: zero field on every channel
        tag = "R3";
        set_cfg(32'h00_00_00_00);
        run(50);

        // R6: change only channel 2, others keep running
        tag = "R6";
        set_cfg(32'h07_0B_03_01);
        run(37);
        set_cfg(32'h07_0B_1C_01);
        run(200);

        // R5: rapid restarts on a single channel
        tag = "R5";
        for (int r = 0; r < 20; r++) begin
            set_cfg({cfg[31:8], 8'(r)});
            run(r % 5);
        end

        // R2: constrained random fields, held for random spans
        tag = "R2";
        for (int r = 0; r < 200; r++) begin
            v = cfg;
            for (int i = 0; i < 4; i++) begin
                if ($urandom % 3 == 0) begin
                    case ($urandom % 5)
                        0: v[i*8 +: 8] = 8'd0;
                        1: v[i*8 +: 8] = 8'd1;
                        2: v[i*8 +: 8] = 8'd2;
                        3: v[i*8 +: 8] = 8'd255;
                        default: v[i*8 +: 8] = 8'($urandom);
                    endcase
                end
            end
            set_cfg(v);
            run(1 + int'($urandom % 300));
        end

        // R4: adjacency across the whole run for fields of 2 or more
        checks++;
        if (adj_viol != 0) begin
            errors++;
            $display("FAIL R4 adjacent ticks: actual=%0d expected=0", adj_viol);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule